// File: doc/BRIEF.md
# Shared Pipelined Functional Unit Arbiter

This block connects a cluster of in-order cores, each holding a single thread, to a small number of shared copies of a costly arithmetic unit. The unit is fully pipelined with a fixed latency, as for example a multiplier or a reciprocal square root. The cores are split into equal, fixed partitions. Each shared unit serves only the cores of its own partition, so no full crossbar is needed between all cores and all units.

In every cycle, each unit takes at most one operation from its partition. A round-robin arbiter picks which one. A core whose request is not granted keeps its request asserted and stalls until a later grant. A granted operation leaves the unit after exactly the configured latency, together with the index of the issuing core and the core's destination-register tag. The arithmetic is a stand-in: the low OPW bits of the product of the two operands.

Top module: `shared_fu_cluster`

## Requirements
- R1: After reset, every `res_valid` bit is 0. In each partition, the first round-robin search starts at the partition's lowest-numbered core.
- R2: Core i is served only by unit i / (NUM_CORES/NUM_UNITS), using integer division. Its result appears on that unit's slice of the result outputs, with `res_core` equal to i.
- R3: In each partition, at most one grant bit is high per cycle. A grant bit is high only for a core whose `req_valid` bit is high in that cycle.
- R4: Round-robin order. Inside a partition, the grant goes to the first requesting core found by searching upward from the pointer, wrapping past the top of the partition. After a grant to partition position w, the pointer moves to w+1 modulo the partition size. The pointer holds when nothing is granted.
- R5: An operation granted in cycle c appears in cycle c+LATENCY on its unit's outputs. `res_valid` is 1, `res_tag` is the core's tag, and `res_data` is the low OPW bits of `req_a` times `req_b`.
- R6: Each unit accepts a new operation in every cycle. Grants in consecutive cycles produce results in consecutive cycles.
- R7: A core whose request is not granted gets no result. When it is granted later, its held operands and tag produce the result.
- R8: Partitions are independent. Grants in different partitions can occur in the same cycle, and each yields its own result.
- R9: A unit that issued nothing LATENCY cycles earlier shows `res_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | One request bit per core, held until granted |
| req_a | input | NUM_CORES*OPW | First operand of each core, core i at bits i*OPW |
| req_b | input | NUM_CORES*OPW | Second operand of each core |
| req_tag | input | NUM_CORES*TAGW | Destination register tag of each core |
| req_grant | output | NUM_CORES | Grant per core, combinational in the request cycle |
| res_valid | output | NUM_UNITS | Result valid per unit |
| res_core | output | NUM_UNITS*CIDW | Index of the issuing core per unit |
| res_tag | output | NUM_UNITS*TAGW | Returned register tag per unit |
| res_data | output | NUM_UNITS*OPW | Result per unit |

## Verification
The block is tested with four load patterns. Under full load, every core requests again as soon as it is granted. This keeps each arbiter saturated and shows whether the pointer rotates through every partition member rather than favouring low indices. A sparse pseudo-random pattern creates gaps and wrap-arounds, so it separates a correct "search from the pointer" rule from a fixed-priority encoder and shows the pointer holding during idle cycles. A pattern with one steady requester per partition issues back to back and checks full pipelining and the exact latency. An idle tail checks that no stray results appear.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  // unit serving a given core under the static partition
  function automatic int unsigned unit_of(input int unsigned core, input int unsigned group);
    return core / group;
  endfunction

  // pointer value after a grant to partition position w
  function automatic int unsigned rr_next(input int unsigned w, input int unsigned group);
    return (w + 1) % group;
  endfunction
endpackage

// File: rtl/sfu_rr_arbiter.sv
module sfu_rr_arbiter #(
  parameter int GROUP = 8,
  localparam int IW = (GROUP > 1) ? $clog2(GROUP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GROUP-1:0] req,
  output logic [GROUP-1:0] gnt,
  output logic [IW-1:0]    win,
  output logic             fire
);
  logic [IW-1:0] ptr;

  always_comb begin
    gnt  = '0;
    win  = '0;
    fire = 1'b0;
    for (int k = 0; k < GROUP; k++) begin
      int idx;
      idx = (int'(ptr) + k) % GROUP;
      if (!fire && req[idx]) begin
        fire     = 1'b1;
        gnt[idx] = 1'b1;
        win      = IW'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (fire) begin
      ptr <= IW'(sfu_pkg::rr_next(int'(win), GROUP));
    end
  end
endmodule

// File: rtl/sfu_pipe.sv
module sfu_pipe #(
  parameter int OPW     = 16,
  parameter int TAGW    = 7,
  parameter int CIDW    = 5,
  parameter int LATENCY = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [CIDW-1:0] in_core,
  input  logic [TAGW-1:0] in_tag,
  input  logic [OPW-1:0]  in_a,
  input  logic [OPW-1:0]  in_b,
  output logic            out_valid,
  output logic [CIDW-1:0] out_core,
  output logic [TAGW-1:0] out_tag,
  output logic [OPW-1:0]  out_data
);
  function automatic logic [OPW-1:0] fu_calc(input logic [OPW-1:0] a, input logic [OPW-1:0] b);
    logic [2*OPW-1:0] p;
    p = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
    return p[OPW-1:0];
  endfunction

  logic            st_v    [LATENCY];
  logic [CIDW-1:0] st_core [LATENCY];
  logic [TAGW-1:0] st_tag  [LATENCY];
  logic [OPW-1:0]  st_data [LATENCY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LATENCY; s++) begin
        st_v[s]    <= 1'b0;
        st_core[s] <= '0;
        st_tag[s]  <= '0;
        st_data[s] <= '0;
      end
    end else begin
      st_v[0]    <= in_valid;
      st_core[0] <= in_core;
      st_tag[0]  <= in_tag;
      st_data[0] <= fu_calc(in_a, in_b);
      for (int s = 1; s < LATENCY; s++) begin
        st_v[s]    <= st_v[s-1];
        st_core[s] <= st_core[s-1];
        st_tag[s]  <= st_tag[s-1];
        st_data[s] <= st_data[s-1];
      end
    end
  end

  assign out_valid = st_v[LATENCY-1];
  assign out_core  = st_core[LATENCY-1];
  assign out_tag   = st_tag[LATENCY-1];
  assign out_data  = st_data[LATENCY-1];
endmodule

// File: rtl/shared_fu_cluster.sv
module shared_fu_cluster #(
  parameter int NUM_CORES = 32,
  parameter int NUM_UNITS = 4,
  parameter int LATENCY   = 3,
  parameter int OPW       = 16,
  parameter int TAGW      = 7,
  localparam int CIDW     = $clog2(NUM_CORES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CORES-1:0]      req_valid,
  input  logic [NUM_CORES*OPW-1:0]  req_a,
  input  logic [NUM_CORES*OPW-1:0]  req_b,
  input  logic [NUM_CORES*TAGW-1:0] req_tag,
  output logic [NUM_CORES-1:0]      req_grant,
  output logic [NUM_UNITS-1:0]      res_valid,
  output logic [NUM_UNITS*CIDW-1:0] res_core,
  output logic [NUM_UNITS*TAGW-1:0] res_tag,
  output logic [NUM_UNITS*OPW-1:0]  res_data
);
  localparam int GROUP = NUM_CORES / NUM_UNITS;
  localparam int IW    = (GROUP > 1) ? $clog2(GROUP) : 1;

  // per-unit issue events, brought out for the checker
  logic [NUM_UNITS-1:0] unit_fire;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [IW-1:0]   win;
    logic [CIDW-1:0] core_id;
    int              sel;

    sfu_rr_arbiter #(.GROUP(GROUP)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (req_valid[u*GROUP +: GROUP]),
      .gnt  (req_grant[u*GROUP +: GROUP]),
      .win  (win),
      .fire (unit_fire[u])
    );

    assign sel     = u * GROUP + int'(win);
    assign core_id = CIDW'(sel);

    sfu_pipe #(.OPW(OPW), .TAGW(TAGW), .CIDW(CIDW), .LATENCY(LATENCY)) u_pipe (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (unit_fire[u]),
      .in_core  (core_id),
      .in_tag   (req_tag[sel*TAGW +: TAGW]),
      .in_a     (req_a[sel*OPW +: OPW]),
      .in_b     (req_b[sel*OPW +: OPW]),
      .out_valid(res_valid[u]),
      .out_core (res_core[u*CIDW +: CIDW]),
      .out_tag  (res_tag[u*TAGW +: TAGW]),
      .out_data (res_data[u*OPW +: OPW])
    );
  end
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int NUM_CORES = 32,
  parameter int NUM_UNITS = 4,
  parameter int LATENCY   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CORES-1:0] req_valid,
  input logic [NUM_CORES-1:0] req_grant,
  input logic [NUM_UNITS-1:0] res_valid,
  input logic [NUM_UNITS-1:0] unit_fire
);
  localparam int GROUP = NUM_CORES / NUM_UNITS;

  assert_grant_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_grant & ~req_valid) == '0);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> res_valid == '0);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    logic [LATENCY-1:0] fire_sh;
    always_ff @(posedge clk) begin
      if (!rst_n) fire_sh <= '0;
      else        fire_sh <= {fire_sh[LATENCY-1:0], unit_fire[u]} [LATENCY-1:0];
    end

    assert_one_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_grant[u*GROUP +: GROUP]));

    assert_exact_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid[u] == fire_sh[LATENCY-1]);

    for (genvar c = 0; c < GROUP; c++) begin : g_c
      // a winner may not win again while a partition neighbour waits
      assert_no_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant[u*GROUP+c] &&
         ((req_valid[u*GROUP +: GROUP] & ~req_grant[u*GROUP +: GROUP]) != '0))
        |=> !req_grant[u*GROUP+c]);
    end
  end
endmodule

bind shared_fu_cluster sfu_checker #(
  .NUM_CORES(NUM_CORES), .NUM_UNITS(NUM_UNITS), .LATENCY(LATENCY)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_grant(req_grant),
  .res_valid(res_valid),
  .unit_fire(unit_fire)
);

// File: tb/sim_shared_fu_cluster.sv
`timescale 1ns/1ps
module sim_shared_fu_cluster;
  localparam int NC = 32;
  localparam int NU = 4;
  localparam int L  = 3;
  localparam int W  = 16;
  localparam int TW = 7;
  localparam int CW = 5;
  localparam int G  = NC / NU;
  localparam int RING = L + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req_valid = '0;
  logic [NC*W-1:0]   req_a = '0;
  logic [NC*W-1:0]   req_b = '0;
  logic [NC*TW-1:0]  req_tag = '0;
  logic [NC-1:0]     req_grant;
  logic [NU-1:0]     res_valid;
  logic [NU*CW-1:0]  res_core;
  logic [NU*TW-1:0]  res_tag;
  logic [NU*W-1:0]   res_data;

  always #4 clk = ~clk;  // 125 MHz

  shared_fu_cluster #(.NUM_CORES(NC), .NUM_UNITS(NU), .LATENCY(L), .OPW(W), .TAGW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_a(req_a), .req_b(req_b),
    .req_tag(req_tag), .req_grant(req_grant), .res_valid(res_valid), .res_core(res_core),
    .res_tag(res_tag), .res_data(res_data));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  bit pend [NC];
  int pa [NC];
  int pb [NC];
  int ptg[NC];
  int ptr[NU];
  bit ev [NU][RING];
  int ec [NU][RING];
  int et [NU][RING];
  int ed [NU][RING];
  int seed = 32'h1234_5678;
  int tagctr = 0;

  function automatic int rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed & 32'h7fff_ffff;
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  task automatic drive();
    for (int c = 0; c < NC; c++) begin
      req_valid[c] = pend[c];
      req_a[c*W +: W] = W'(pa[c]);
      req_b[c*W +: W] = W'(pb[c]);
      req_tag[c*TW +: TW] = TW'(ptg[c]);
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin pend[c] = 0; pa[c] = 0; pb[c] = 0; ptg[c] = 0; end
    for (int u = 0; u < NU; u++) begin
      ptr[u] = 0;
      for (int s = 0; s < RING; s++) ev[u][s] = 0;
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(res_valid == '0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(req_grant == '0, "R1 grant with no request", int'(req_grant), 0);

    for (int cyc = 0; cyc < 1200; cyc++) begin
      int slot;
      if (cyc > 0) @(negedge clk);
      slot = cyc % RING;
      // R5 R6 R9: results of this cycle
      for (int u = 0; u < NU; u++) begin
        chk(res_valid[u] == ev[u][slot], "R5 R6 R9 res_valid", int'(res_valid[u]), int'(ev[u][slot]));
        if (ev[u][slot] && res_valid[u]) begin
          chk(int'(res_core[u*CW +: CW]) == ec[u][slot], "R2 res_core", int'(res_core[u*CW +: CW]), ec[u][slot]);
          chk(int'(res_tag[u*TW +: TW]) == et[u][slot], "R5 R7 res_tag", int'(res_tag[u*TW +: TW]), et[u][slot]);
          chk(int'(res_data[u*W +: W]) == ed[u][slot], "R5 res_data", int'(res_data[u*W +: W]), ed[u][slot]);
        end
        ev[u][slot] = 0;
      end
      // new requests: full load, sparse, one steady requester (R6), idle
      for (int c = 0; c < NC; c++) begin
        bit mk;
        if (cyc < 300)       mk = 1;
        else if (cyc < 900)  mk = (rnd() % 4) == 0;
        else if (cyc < 1100) mk = (c % G) == 3;
        else                 mk = 0;
        if (!pend[c] && mk) begin
          pend[c] = 1;
          pa[c] = rnd() & 16'hffff;
          pb[c] = rnd() & 16'hffff;
          ptg[c] = tagctr % (1 << TW);
          tagctr++;
        end
      end
      drive();
      #1;
      // R3 R4 R7 R8: expected grants from the rotating search
      for (int u = 0; u < NU; u++) begin
        int wc;
        wc = -1;
        for (int k = 0; k < G; k++) begin
          int c;
          c = u * G + (ptr[u] + k) % G;
          if (wc < 0 && pend[c]) wc = c;
        end
        for (int k = 0; k < G; k++) begin
          int c;
          c = u * G + k;
          chk(req_grant[c] == (c == wc), "R3 R4 R7 R8 grant", int'(req_grant[c]), int'(c == wc));
        end
        if (wc >= 0) begin
          int ds;
          ds = (cyc + L) % RING;
          ev[u][ds] = 1;
          ec[u][ds] = wc;
          et[u][ds] = ptg[wc];
          ed[u][ds] = int'((longint'(pa[wc]) * longint'(pb[wc])) & 64'hffff);
          ptr[u] = (wc - u * G + 1) % G;
          pend[wc] = 0;
        end
      end
    end
    drive();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule